// File: doc/BRIEF.md
# Cascadable Serial LED Data Register

This block is the digital data path of an LED sink driver with a parameterizable number of channels, eight by default. Serial data is shifted into a register on the rising edges of an external shift clock. A level-sensitive output latch passes the register contents to the channel on/off signals. An active-low enable forces every channel off. The last register stage is brought out on a cascade output so that several devices can be chained.

All external control pins are asynchronous to the block's fast system clock. Each one passes through a synchronizer, and the shift-clock edges are found by comparing synchronized samples. A neighbouring mode controller can replace the serial input with a parallel word, or it can hold the latch shut while it is decoding a mode-switch pattern.

Top module: `led_shift_chain`

## Requirements
- R1: On each synchronized rising edge of `sck_in`, the register shifts one place toward the top channel, and `sdi_in` enters at channel 0. After CHANNELS rising edges, the first bit shifted in sits at channel CHANNELS-1 and the newest bit sits at channel 0.
- R2: `sdo` carries the top register stage as it was at a synchronized falling edge of `sck_in`. A rising edge never changes `sdo`.
- R3: While the synchronized `lat_in` is high, the latch follows the register. While it is low, the latch keeps its value, even if the register keeps shifting.
- R4: While the synchronized `oe_n_in` is low, `chan_on[i]` equals latch bit i. While it is high, every bit of `chan_on` is 0.
- R5: While `rst_n` is low, the register, the latch and `sdo` are cleared, so `chan_on` and `sdo` read 0 after reset.
- R6: When `pload_sel` is high at a rising shift edge, the register takes `pload_data` whole, with bit i going to channel i, and the serial input is not used.
- R7: While `lat_block` is high, the latch holds its value even when `lat_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_in | input | 1 | External shift clock |
| sdi_in | input | 1 | Serial data input |
| lat_in | input | 1 | Latch transparency control, high means transparent |
| oe_n_in | input | 1 | Active-low output enable |
| lat_block | input | 1 | Blocks latch transparency (from the mode controller) |
| pload_sel | input | 1 | Selects the parallel word instead of the serial input |
| pload_data | input | CHANNELS | Parallel word loaded at a shift edge |
| chan_on | output | CHANNELS | Channel on/off signals, 1 means on |
| sdo | output | 1 | Cascade serial output |

## Verification
The bench builds the block with CHANNELS=8 and SYNC_STAGES=2. With eight channels, a short run can cover a full byte, a sixteen-bit pass through the register that shows the cascade output, and random mixes of latch, enable, block and parallel-load events. Two synchronizer stages keep the delay from a pin to the register short, so each pin level only has to be held for a few system clocks before the reference model and the outputs agree.

// File: rtl/led_shift_chain.sv
module led_shift_chain #(
  parameter int CHANNELS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_in,
  input  logic                sdi_in,
  input  logic                lat_in,
  input  logic                oe_n_in,
  input  logic                lat_block,
  input  logic                pload_sel,
  input  logic [CHANNELS-1:0] pload_data,
  output logic [CHANNELS-1:0] chan_on,
  output logic                sdo
);
  localparam int TOP = CHANNELS - 1;
  localparam int LST = SYNC_STAGES - 1;

  // pin order inside each stage: {oe_n, lat, sdi, sck}
  logic [3:0] sy [SYNC_STAGES];
  logic       sck_d;
  logic [TOP:0] sr_q, latch_q;
  logic       sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sy[i] <= 4'b1000;
      sck_d <= 1'b0;
    end else begin
      sy[0] <= {oe_n_in, lat_in, sdi_in, sck_in};
      for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
      sck_d <= sy[LST][0];
    end
  end

  wire sck_s    = sy[LST][0];
  wire sdi_s    = sy[LST][1];
  wire lat_s    = sy[LST][2];
  wire oe_n_s   = sy[LST][3];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire lat_open = lat_s & ~lat_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      latch_q <= '0;
      sdo_q   <= 1'b0;
    end else begin
      if (sck_rise) sr_q <= pload_sel ? pload_data : {sr_q[TOP-1:0], sdi_s};
      if (sck_fall) sdo_q <= sr_q[TOP];
      if (lat_open) latch_q <= sr_q;
    end
  end

  assign chan_on = oe_n_s ? '0 : latch_q;
  assign sdo     = sdo_q;

  // R1
  sr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(sr_q));
  // R2
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_q != $past(sdo_q)) |-> $past(sck_fall));
  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_s |=> $stable(latch_q));
  // R4
  gate_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_on & ~latch_q) == 0);
  // R7
  latch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_block |=> $stable(latch_q));
endmodule

// File: tb/tb_led_shift_chain.sv
module tb_led_shift_chain;
  localparam int CH = 8;
  logic clk = 0, rst_n = 0;
  logic sck = 0, sdi = 0, lat = 0, oe_n = 1, blk = 0, psel = 0;
  logic [CH-1:0] pdata = '0;
  logic [CH-1:0] chan_on;
  logic sdo;
  logic [CH-1:0] m_sr = '0, m_lat = '0;
  logic m_sdo = 0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  led_shift_chain #(.CHANNELS(CH), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sck_in(sck), .sdi_in(sdi), .lat_in(lat),
    .oe_n_in(oe_n), .lat_block(blk), .pload_sel(psel), .pload_data(pdata),
    .chan_on(chan_on), .sdo(sdo));

  function automatic logic [CH-1:0] exp_chan(logic en_n, logic [CH-1:0] l);
    return en_n ? '0 : l;
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag);
    checks += 2;
    if (chan_on !== exp_chan(oe_n, m_lat)) begin
      errors++;
      $display("FAIL %s chan_on actual=%b expected=%b", tag, chan_on, exp_chan(oe_n, m_lat));
    end
    if (sdo !== m_sdo) begin
      errors++;
      $display("FAIL %s sdo actual=%b expected=%b", tag, sdo, m_sdo);
    end
  endtask

  task automatic set_lat(logic v);
    lat = v; wait_n(6);
    if (lat && !blk) m_lat = m_sr;
  endtask

  task automatic pulse(logic d, logic p, logic [CH-1:0] w, string tag);
    sdi = d; psel = p; pdata = w; wait_n(4);
    sck = 1; wait_n(6);
    m_sr = p ? w : {m_sr[CH-2:0], d};
    if (lat && !blk) m_lat = m_sr;
    check({tag, " rise (R2 no sdo change)"});
    sck = 0; wait_n(6);
    m_sdo = m_sr[CH-1];
    check({tag, " fall"});
    psel = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [CH-1:0] byte_v;
    void'($urandom(32'd2024));
    wait_n(3);
    check("R5 reset");
    rst_n = 1; wait_n(3);
    check("R5 after reset");
    oe_n = 0; wait_n(6);
    check("R5 enabled after reset");

    // R1/R3: shift a byte with latch closed, then open it
    byte_v = 8'b1011_0010;
    for (int i = CH - 1; i >= 0; i--) pulse(byte_v[i], 0, '0, "R3 hold while shifting");
    set_lat(1); check("R1 first bit at top channel");
    checks++;
    if (chan_on !== byte_v) begin
      errors++; $display("FAIL R1 chan_on actual=%b expected=%b", chan_on, byte_v);
    end
    set_lat(0);

    // R4
    oe_n = 1; wait_n(6); check("R4 forced off");
    oe_n = 0; wait_n(6); check("R4 enabled");

    // R3 transparent while shifting
    set_lat(1);
    for (int i = 0; i < 3; i++) pulse(1'b1, 0, '0, "R3 transparent");
    set_lat(0);

    // R7 block
    blk = 1; set_lat(1);
    for (int i = 0; i < 3; i++) pulse(1'b0, 0, '0, "R7 blocked latch");
    check("R7 blocked");
    set_lat(0); blk = 0;

    // R6 parallel load
    pulse(1'b0, 1, 8'h5A, "R6 load");
    set_lat(1); check("R6 loaded word"); set_lat(0);

    // R2 cascade: 16 bits through
    for (int i = 0; i < 2 * CH; i++) pulse(i[0] ^ i[2], 0, '0, "R2 cascade");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: begin oe_n = $urandom_range(0, 1); wait_n(6); check("R4 random"); end
        1: set_lat($urandom_range(0, 1));
        2: begin blk = $urandom_range(0, 1); wait_n(2); check("R7 random"); end
        3: pulse(1'b0, 1, CH'($urandom), "R6 random");
        default: pulse($urandom_range(0, 1), 0, '0, "R1 random");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule